// File: doc/BRIEF.md
# Planar Video Memory Write Mapper

This block sits between a host byte port and an external video memory that is organised as words of four byte-wide planes. Each host access carries an address inside a 128 KiB legacy display window. The block folds that address into the window, applies one of four window maps, and turns the result into a memory word index plus a 4-bit plane lane enable. Accesses that fall outside the selected map are flagged as misses. A missed read is answered with the all-ones byte, and a missed write touches nothing.

Three plane-addressing schemes are selected by control bits. In the chained scheme, the two low offset bits pick the plane. In the paired (odd/even) scheme, a page bit and the low offset bit pick the plane and the word index is interleaved. In the planar scheme, every plane of one word is addressed and the map mask picks the lanes that are written. A sticky record keeps every plane that a successful write has touched, so that software or a display engine can tell when the font plane (plane 2) has been rewritten. A dedicated input clears the record.

The results are registered. Every access accepted in one cycle is presented at the outputs in the next cycle.

Top module: `vid_plane_mapper`

## Requirements
- R1: Only address bits 16:0 take part in decoding. Bits above 16 have no effect on any output.
- R2: Map select 0 accepts the whole 128 KiB window, and the offset equals the folded address.
- R3: Map select 1 accepts folded addresses below 0x10000 and adds bank_sel×0x10000 to form the offset. Folded addresses of 0x10000 and above miss.
- R4: Map selects 2 and 3 subtract 0x10000 and 0x18000 respectively, modulo 2^17. A result of 0x8000 or more misses.
- R5: On a miss, out_lane_en and out_word are zero. A read miss gives out_rd_fill = 0xFF, and every other access gives 0x00. A missed write leaves planes_written unchanged.
- R6: With chain4_en set, plane p = offset[1:0] and out_word = offset>>2. out_lane_en is one-hot at bit p. For a write, it is zero when plane_mask[p] is clear.
- R7: With chain4_en clear and oddeven_en set, plane p = {odd_page, offset[0]} and out_word = offset>>1 (the byte address ((offset & ~1)<<1)|p divided by 4). Lanes are formed as in R6.
- R8: With both mode bits clear, out_word = offset. A write enables lanes equal to plane_mask, and a read enables all four lanes.
- R9: chain4_en takes priority over oddeven_en.
- R10: Each non-missing write ORs its lane enable into planes_written. Reads never change it.
- R11: plane_clr empties planes_written. Lanes written in the same cycle as the clear are still recorded.
- R12: font_dirty is 1 exactly when bit 2 of planes_written is set.
- R13: Outputs and planes_written update on the clock edge that follows an accepted access. out_valid pulses for one cycle per access. Without an access, out_word and the other result outputs hold. All outputs are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | HOST_AW (32) | Host byte address |
| map_sel | input | 2 | Window map select (0..3) |
| chain4_en | input | 1 | Chained plane addressing |
| oddeven_en | input | 1 | Paired plane addressing |
| odd_page | input | 1 | Upper plane bit in paired mode |
| plane_mask | input | 4 | Plane write mask |
| bank_sel | input | BANK_W (4) | Bank number for map 1 |
| plane_clr | input | 1 | Clear the written-plane record |
| out_valid | output | 1 | Result of last cycle's access |
| out_write | output | 1 | Result belongs to a write |
| out_miss | output | 1 | Access fell outside the map |
| out_word | output | WORD_AW (18) | Memory word index |
| out_lane_en | output | 4 | Per-plane byte lane enable |
| out_rd_fill | output | 8 | Substitute read data on a miss |
| planes_written | output | 4 | Sticky written-plane record |
| font_dirty | output | 1 | Plane 2 has been written |

## Verification
The hardest behaviour to reach is the meeting point of the sticky record with other events: a clear arriving in the same cycle as a write, a missed write that must leave the record untouched, and a write whose only plane is masked off. The stimulus first builds up a non-empty record through planar and chained writes. It then issues a clear alongside a read, a clear alongside a plane-2 write, a missed write, and a masked chained write. For each of these the bench compares the record with a model that is kept in step access by access. The window boundaries (0xFFFF/0x10000, 0x17FFF/0x18000, 0x1FFFF) and the subtraction wrap-around in maps 2 and 3 are hit directly by chosen addresses.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  localparam int WIN_AW = 17;
  localparam int PLANES = 4;

  typedef enum logic [1:0] {
    MAP_FULL   = 2'd0,
    MAP_BANKED = 2'd1,
    MAP_MONO   = 2'd2,
    MAP_COLOR  = 2'd3
  } map_sel_e;

  typedef enum logic [1:0] {
    ROUTE_CHAIN  = 2'd0,
    ROUTE_PAIRED = 2'd1,
    ROUTE_PLANAR = 2'd2
  } route_e;
endpackage

// File: rtl/vpm_window_decode.sv
module vpm_window_decode
  import vpm_pkg::*;
#(
  parameter int OFS_W  = 20,
  parameter int BANK_W = 4
) (
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [1:0]        map_sel,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [OFS_W-1:0]  offset,
  output logic              hit
);
  localparam logic [WIN_AW-1:0] MONO_BASE  = 17'h10000;
  localparam logic [WIN_AW-1:0] COLOR_BASE = 17'h18000;

  logic [WIN_AW-1:0] mono_rel;
  logic [WIN_AW-1:0] color_rel;
  logic [OFS_W-1:0]  bank_base;

  always_comb begin
    mono_rel  = win_addr - MONO_BASE;
    color_rel = win_addr - COLOR_BASE;
    bank_base = OFS_W'(bank_sel) << 16;
  end

  always_comb begin
    offset = '0;
    hit    = 1'b0;
    unique case (map_sel_e'(map_sel))
      MAP_FULL: begin
        hit    = 1'b1;
        offset = OFS_W'(win_addr);
      end
      MAP_BANKED: begin
        hit    = ~win_addr[16];
        offset = OFS_W'(win_addr[15:0]) + bank_base;
      end
      MAP_MONO: begin
        hit    = ~(|mono_rel[16:15]);
        offset = OFS_W'(mono_rel[14:0]);
      end
      MAP_COLOR: begin
        hit    = ~(|color_rel[16:15]);
        offset = OFS_W'(color_rel[14:0]);
      end
      default: begin
        hit    = 1'b0;
        offset = '0;
      end
    endcase
  end
endmodule

// File: rtl/vpm_plane_route.sv
module vpm_plane_route
  import vpm_pkg::*;
#(
  parameter int OFS_W   = 20,
  parameter int WORD_AW = 18
) (
  input  logic [OFS_W-1:0]   offset,
  input  logic               is_write,
  input  logic               chain4_en,
  input  logic               oddeven_en,
  input  logic               odd_page,
  input  logic [PLANES-1:0]  plane_mask,
  output logic [WORD_AW-1:0] word_idx,
  output logic [PLANES-1:0]  lane_en
);
  route_e            route;
  logic [1:0]        plane_sel;
  logic [OFS_W-1:0]  wide_idx;
  logic [PLANES-1:0] plane_hot;
  logic [PLANES-1:0] lane_allow;

  always_comb begin
    if (chain4_en)       route = ROUTE_CHAIN;
    else if (oddeven_en) route = ROUTE_PAIRED;
    else                 route = ROUTE_PLANAR;
  end

  always_comb begin
    plane_sel = 2'd0;
    wide_idx  = offset;
    unique case (route)
      ROUTE_CHAIN: begin
        plane_sel = offset[1:0];
        wide_idx  = offset >> 2;
      end
      ROUTE_PAIRED: begin
        plane_sel = {odd_page, offset[0]};
        wide_idx  = offset >> 1;
      end
      default: begin
        plane_sel = 2'd0;
        wide_idx  = offset;
      end
    endcase
  end

  for (genvar g = 0; g < PLANES; g++) begin : g_lane
    always_comb begin
      plane_hot[g]  = (plane_sel == 2'(g));
      lane_allow[g] = ~is_write | plane_mask[g];
      lane_en[g]    = (route == ROUTE_PLANAR) ? lane_allow[g]
                                              : (plane_hot[g] & lane_allow[g]);
    end
  end

  assign word_idx = wide_idx[WORD_AW-1:0];
endmodule

// File: rtl/vpm_plane_record.sv
module vpm_plane_record
  import vpm_pkg::*;
#(
  parameter int FONT_PLANE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd_en,
  input  logic [PLANES-1:0] upd_lanes,
  output logic [PLANES-1:0] record,
  output logic              font_flag
);
  logic [PLANES-1:0] rec_q;
  logic [PLANES-1:0] rec_d;
  logic              rec_en;

  always_comb begin
    rec_en = clr | upd_en;
    rec_d  = (clr ? '0 : rec_q) | (upd_en ? upd_lanes : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign record    = rec_q;
  assign font_flag = rec_q[FONT_PLANE];
endmodule

// File: rtl/vid_plane_mapper.sv
module vid_plane_mapper
  import vpm_pkg::*;
#(
  parameter int HOST_AW = 32,
  parameter int WORD_AW = 18,
  parameter int BANK_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic               acc_write,
  input  logic [HOST_AW-1:0] acc_addr,
  input  logic [1:0]         map_sel,
  input  logic               chain4_en,
  input  logic               oddeven_en,
  input  logic               odd_page,
  input  logic [3:0]         plane_mask,
  input  logic [BANK_W-1:0]  bank_sel,
  input  logic               plane_clr,
  output logic               out_valid,
  output logic               out_write,
  output logic               out_miss,
  output logic [WORD_AW-1:0] out_word,
  output logic [3:0]         out_lane_en,
  output logic [7:0]         out_rd_fill,
  output logic [3:0]         planes_written,
  output logic               font_dirty
);
  localparam int OFS_W = WORD_AW + 2;
  localparam logic [7:0] MISS_FILL = 8'hFF;

  logic [WIN_AW-1:0]  win_addr;
  logic               unused_hi;
  logic [OFS_W-1:0]   offset;
  logic               hit;
  logic [WORD_AW-1:0] rt_word;
  logic [PLANES-1:0]  rt_lanes;

  logic               valid_d;
  logic               write_d, miss_d;
  logic [WORD_AW-1:0] word_d;
  logic [PLANES-1:0]  lanes_d;
  logic [7:0]         fill_d;
  logic               rec_upd;

  assign win_addr  = acc_addr[WIN_AW-1:0];
  assign unused_hi = ^acc_addr[HOST_AW-1:WIN_AW];

  vpm_window_decode #(.OFS_W(OFS_W), .BANK_W(BANK_W)) win_i (
    .win_addr (win_addr),
    .map_sel  (map_sel),
    .bank_sel (bank_sel),
    .offset   (offset),
    .hit      (hit)
  );

  vpm_plane_route #(.OFS_W(OFS_W), .WORD_AW(WORD_AW)) route_i (
    .offset     (offset),
    .is_write   (acc_write),
    .chain4_en  (chain4_en),
    .oddeven_en (oddeven_en),
    .odd_page   (odd_page),
    .plane_mask (plane_mask),
    .word_idx   (rt_word),
    .lane_en    (rt_lanes)
  );

  always_comb begin
    valid_d = acc_valid;
    write_d = acc_write;
    miss_d  = ~hit;
    word_d  = hit ? rt_word  : '0;
    lanes_d = hit ? rt_lanes : '0;
    fill_d  = (~hit & ~acc_write) ? MISS_FILL : 8'h00;
    rec_upd = acc_valid & acc_write & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_write   <= 1'b0;
      out_miss    <= 1'b0;
      out_word    <= '0;
      out_lane_en <= '0;
      out_rd_fill <= '0;
    end else if (acc_valid) begin
      out_write   <= write_d;
      out_miss    <= miss_d;
      out_word    <= word_d;
      out_lane_en <= lanes_d;
      out_rd_fill <= fill_d;
    end
  end

  vpm_plane_record #(.FONT_PLANE(2)) rec_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (plane_clr),
    .upd_en    (rec_upd),
    .upd_lanes (lanes_d),
    .record    (planes_written),
    .font_flag (font_dirty)
  );
endmodule

// File: rtl/vid_plane_mapper_chk.sv
module vid_plane_mapper_chk #(
  parameter int WORD_AW = 18
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic               acc_write,
  input logic               chain4_en,
  input logic               plane_clr,
  input logic               out_valid,
  input logic               out_write,
  input logic               out_miss,
  input logic [WORD_AW-1:0] out_word,
  input logic [3:0]         out_lane_en,
  input logic [7:0]         out_rd_fill,
  input logic [3:0]         planes_written,
  input logic               font_dirty
);
  p_miss_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_lane_en == 4'b0));

  p_fill_read_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_write) |-> (out_rd_fill == 8'h00));

  p_chain_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && chain4_en) |=> $onehot0(out_lane_en));

  p_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !out_valid);

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(out_word));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (plane_clr && !(acc_valid && acc_write)) |=> (planes_written == 4'b0));

  p_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !plane_clr |=> ((planes_written & $past(planes_written)) == $past(planes_written)));

  p_read_no_record_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!plane_clr && !(acc_valid && acc_write)) |=> $stable(planes_written));

  p_font_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(font_dirty) |-> $past(acc_valid && acc_write));
endmodule

bind vid_plane_mapper vid_plane_mapper_chk #(.WORD_AW(WORD_AW)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_write      (acc_write),
  .chain4_en      (chain4_en),
  .plane_clr      (plane_clr),
  .out_valid      (out_valid),
  .out_write      (out_write),
  .out_miss       (out_miss),
  .out_word       (out_word),
  .out_lane_en    (out_lane_en),
  .out_rd_fill    (out_rd_fill),
  .planes_written (planes_written),
  .font_dirty     (font_dirty)
);

// File: tb/vid_plane_mapper_tb_top.sv
module vid_plane_mapper_tb_top;
  localparam int HOST_AW = 32;
  localparam int WORD_AW = 18;
  localparam int BANK_W  = 4;

  typedef struct {
    logic [WORD_AW-1:0] word;
    logic [3:0]         lanes;
    logic               miss;
    logic               write;
    logic [7:0]         fill;
    logic [3:0]         rec;
    string              tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, acc_write, chain4_en, oddeven_en, odd_page, plane_clr;
  logic [HOST_AW-1:0] acc_addr;
  logic [1:0] map_sel;
  logic [3:0] plane_mask;
  logic [BANK_W-1:0] bank_sel;
  logic out_valid, out_write, out_miss, font_dirty;
  logic [WORD_AW-1:0] out_word;
  logic [3:0] out_lane_en, planes_written;
  logic [7:0] out_rd_fill;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];
  logic [3:0] model_rec;

  always #4 clk = ~clk;

  vid_plane_mapper #(.HOST_AW(HOST_AW), .WORD_AW(WORD_AW), .BANK_W(BANK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .map_sel(map_sel), .chain4_en(chain4_en),
    .oddeven_en(oddeven_en), .odd_page(odd_page), .plane_mask(plane_mask),
    .bank_sel(bank_sel), .plane_clr(plane_clr), .out_valid(out_valid),
    .out_write(out_write), .out_miss(out_miss), .out_word(out_word),
    .out_lane_en(out_lane_en), .out_rd_fill(out_rd_fill),
    .planes_written(planes_written), .font_dirty(font_dirty)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirement list
  task automatic do_acc(input bit wr, input logic [31:0] addr, input bit clr, input string tag);
    exp_t e;
    logic [31:0] a, off;
    logic miss;
    logic [1:0] p;
    logic [31:0] w;
    logic [3:0] ln;
    a = addr & 32'h1FFFF;                      // R1
    miss = 1'b0;
    off = a;
    case (map_sel)
      2'd0: off = a;                           // R2
      2'd1: begin                              // R3
        miss = (a >= 32'h10000);
        off = a + (32'(bank_sel) << 16);
      end
      2'd2: begin                              // R4
        off = (a - 32'h10000) & 32'h1FFFF;
        miss = (off >= 32'h8000);
      end
      default: begin                           // R4
        off = (a - 32'h18000) & 32'h1FFFF;
        miss = (off >= 32'h8000);
      end
    endcase
    if (chain4_en) begin                       // R6, R9
      p = off[1:0]; w = off >> 2;
      ln = (!wr || plane_mask[p]) ? (4'b1 << p) : 4'b0;
    end else if (oddeven_en) begin             // R7
      p = {odd_page, off[0]};
      w = (((off & ~32'd1) << 1) | 32'(p)) >> 2;
      ln = (!wr || plane_mask[p]) ? (4'b1 << p) : 4'b0;
    end else begin                             // R8
      w = off; ln = wr ? plane_mask : 4'hF;
    end
    if (miss) begin w = 0; ln = 0; end         // R5
    if (clr) model_rec = 4'b0;                 // R11
    if (wr && !miss) model_rec = model_rec | ln; // R10
    e.word = w[WORD_AW-1:0];
    e.lanes = ln;
    e.miss = miss;
    e.write = wr;
    e.fill = (miss && !wr) ? 8'hFF : 8'h00;
    e.rec = model_rec;
    e.tag = tag;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = addr; plane_clr = clr;
    exp_q.push_back(e);
    @(negedge clk);
    acc_valid = 1'b0; plane_clr = 1'b0;
  endtask

  // Monitor: compares results one step after the capturing edge
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R13 unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " word"},  32'(out_word),       32'(e.word));
        check({e.tag, " lanes"}, 32'(out_lane_en),    32'(e.lanes));
        check({e.tag, " miss"},  32'(out_miss),       32'(e.miss));
        check({e.tag, " write"}, 32'(out_write),      32'(e.write));
        check({e.tag, " fill"},  32'(out_rd_fill),    32'(e.fill));
        check({e.tag, " record"},32'(planes_written), 32'(e.rec));
        check({e.tag, " R12 font"}, 32'(font_dirty),  32'(e.rec[2]));
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [WORD_AW-1:0] held;
    rst_n = 1'b0; acc_valid = 0; acc_write = 0; acc_addr = 0; map_sel = 0;
    chain4_en = 0; oddeven_en = 0; odd_page = 0; plane_mask = 0; bank_sel = 0;
    plane_clr = 0; model_rec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 reset out_valid", 32'(out_valid), 0);
    check("R13 reset out_word", 32'(out_word), 0);
    check("R12 reset record", 32'(planes_written), 0);

    map_sel = 0; plane_mask = 4'b0101;
    do_acc(1, 32'hABCD_2345 | 32'h0001_0000, 0, "R1 R2 R8 planar write");
    do_acc(0, 32'h0000_0777, 0, "R8 planar read");
    map_sel = 1; bank_sel = 4'd3;
    do_acc(1, 32'h0000_0ABC, 0, "R3 banked write");
    do_acc(0, 32'h0000_FFFF, 0, "R3 banked top");
    do_acc(0, 32'h0001_0000, 0, "R3 R5 banked read miss");
    map_sel = 2;
    do_acc(0, 32'h0001_0010, 0, "R4 map2 hit");
    do_acc(0, 32'h0001_8000, 0, "R4 map2 upper miss");
    do_acc(0, 32'h0000_FFFF, 0, "R4 map2 wrap miss");
    map_sel = 3;
    do_acc(0, 32'h0001_8004, 0, "R4 map3 hit");
    do_acc(0, 32'h0001_FFFF, 0, "R4 map3 top");
    do_acc(1, 32'h0001_7FFF, 0, "R4 R5 map3 write miss");
    map_sel = 0; chain4_en = 1; plane_mask = 4'b1010;
    do_acc(1, 32'h0000_0105, 0, "R6 chain write");
    do_acc(1, 32'h0000_0106, 0, "R6 chain masked write");
    do_acc(0, 32'h0000_0106, 0, "R6 chain read");
    oddeven_en = 1;
    do_acc(1, 32'h0000_0203, 0, "R9 chain over paired");
    chain4_en = 0; odd_page = 1; plane_mask = 4'hF;
    do_acc(1, 32'h0000_0021, 0, "R7 paired odd page");
    odd_page = 0; plane_mask = 4'b1110;
    do_acc(1, 32'h0000_0020, 0, "R7 paired masked");
    do_acc(0, 32'h0000_0031, 0, "R7 R10 paired read");
    do_acc(0, 32'h0000_0000, 1, "R11 clear with read");
    oddeven_en = 0; chain4_en = 1; plane_mask = 4'hF;
    do_acc(1, 32'h0000_0002, 1, "R11 R12 clear with plane2 write");
    map_sel = 2;
    do_acc(1, 32'h0000_0001, 0, "R5 R10 missed write keeps record");

    repeat (3) @(negedge clk);
    check("R13 queue drained", 32'(exp_q.size()), 0);
    held = out_word;
    repeat (2) @(negedge clk);
    check("R13 idle out_valid", 32'(out_valid), 0);
    check("R13 idle hold word", 32'(out_word), 32'(held));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule